// File: doc/BRIEF.md
# Compare and Test Flag Unit

This block produces the condition flags that an 8-bit accumulator machine needs for its two non-destructive ALU operations. In compare mode it subtracts the operand from the accumulator and keeps only the flags of that difference. In test mode it ANDs the two values and keeps only the flags of that product. In neither mode is the accumulator written: the value that comes in goes out unchanged.

Next to the six flags (sign, zero, parity/overflow, half-carry, subtract, carry), the unit drives three ordering outputs: unsigned less-than, signed less-than and equality. These always come from the subtraction, whichever mode is selected. A branch unit can therefore read an ordering result without re-encoding the flag word. Signed ordering comes from the same flag word as unsigned ordering. The parity/overflow bit holds overflow on the subtract path and parity on the logic path. The block has no state: every output is a function of the present inputs.

Top module: `cmpt_flag_unit`

## Requirements
- R1: `acc_o` equals `acc_i` for every input combination and in both modes.
- R2: `eq_o` is 1 exactly when A equals N, in both modes. In compare mode `flg_zero_o` is 1 exactly when A equals N.
- R3: In compare mode `flg_carry_o` is 1 exactly when A < N as unsigned numbers. `ult_o` gives the same unsigned comparison in both modes.
- R4: In compare mode `flg_sign_o` is bit 7 of A−N. `flg_pv_o` is the two's-complement overflow of A−N: it is 1 when A and N differ in sign and the sign of the difference differs from the sign of A.
- R5: `slt_o` is 1 exactly when A < N as signed numbers, in both modes. In compare mode it equals `flg_sign_o` XOR `flg_pv_o`.
- R6: In compare mode `flg_half_o` is the borrow out of bit 3, which is 1 when A[3:0] < N[3:0] as unsigned numbers. `flg_sub_o` is 1 in this mode.
- R7: In test mode `flg_sign_o` is bit 7 of A AND N. `flg_zero_o` is 1 exactly when A AND N is zero.
- R8: In test mode `flg_pv_o` is 1 when A AND N holds an even number of one bits, zero included, and 0 when the count is odd.
- R9: In test mode `flg_half_o` is 1, and `flg_sub_o` and `flg_carry_o` are 0.
- R10: `op_test_i` = 0 selects compare and `op_test_i` = 1 selects test. The outputs follow input changes with no clock.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| acc_i | input | 8 | Accumulator value A |
| opnd_i | input | 8 | Operand N |
| op_test_i | input | 1 | 0 = compare (A−N), 1 = test (A AND N) |
| acc_o | output | 8 | Accumulator passed through unchanged |
| flg_sign_o | output | 1 | Sign flag |
| flg_zero_o | output | 1 | Zero flag |
| flg_pv_o | output | 1 | Parity/overflow flag |
| flg_half_o | output | 1 | Half-carry flag |
| flg_sub_o | output | 1 | Subtract flag |
| flg_carry_o | output | 1 | Carry flag |
| ult_o | output | 1 | A < N unsigned |
| slt_o | output | 1 | A < N signed |
| eq_o | output | 1 | A equals N |

## Verification
Signed overflow on compare is the case that is hardest to reach. It occurs only when A and N straddle zero and the true difference lies outside −128..127. Only that case separates `slt_o` from the plain sign bit. A sign error in the overflow term can therefore hide behind most ordinary operand pairs. The directed table contains pairs such as 0x80 against 0x01 and 0x7F against 0xFF. After the table, the bench sweeps all 65,536 operand pairs in both modes against a model that works out ordering from integer comparison, not from flag algebra.

// File: rtl/cmpt_pkg.sv
package cmpt_pkg;
  localparam int unsigned DATA_W = 8;
  localparam int unsigned NIB_W  = DATA_W / 2;

  typedef struct packed {
    logic sign;
    logic zero;
    logic pv;
    logic half;
    logic sub;
    logic carry;
  } flags_t;
endpackage

// File: rtl/cmpt_sub_path.sv
module cmpt_sub_path
  import cmpt_pkg::*;
#(
  parameter int unsigned W = DATA_W
) (
  input  logic [W-1:0] a_i,
  input  logic [W-1:0] b_i,
  output flags_t       fl_o,
  output logic         ult_o,
  output logic         slt_o
);
  localparam int unsigned NW = W / 2;

  logic [W:0]  diff;
  logic [NW:0] low_diff;
  logic        ovf;

  always_comb begin
    diff     = {1'b0, a_i} - {1'b0, b_i};
    low_diff = {1'b0, a_i[NW-1:0]} - {1'b0, b_i[NW-1:0]};
    ovf      = (a_i[W-1] ^ b_i[W-1]) & (diff[W-1] ^ a_i[W-1]);

    fl_o.sign  = diff[W-1];
    fl_o.zero  = (diff[W-1:0] == '0);
    fl_o.pv    = ovf;
    fl_o.half  = low_diff[NW];
    fl_o.sub   = 1'b1;
    fl_o.carry = diff[W];

    ult_o = diff[W];
    slt_o = diff[W-1] ^ ovf;
  end
endmodule

// File: rtl/cmpt_and_path.sv
module cmpt_and_path
  import cmpt_pkg::*;
#(
  parameter int unsigned W = DATA_W
) (
  input  logic [W-1:0] a_i,
  input  logic [W-1:0] b_i,
  output flags_t       fl_o
);
  logic [W-1:0] prod;

  always_comb begin
    prod       = a_i & b_i;
    fl_o.sign  = prod[W-1];
    fl_o.zero  = (prod == '0);
    fl_o.pv    = ~(^prod);
    fl_o.half  = 1'b1;
    fl_o.sub   = 1'b0;
    fl_o.carry = 1'b0;
  end
endmodule

// File: rtl/cmpt_flag_unit.sv
module cmpt_flag_unit
  import cmpt_pkg::*;
#(
  parameter int unsigned W = DATA_W
) (
  input  logic [W-1:0] acc_i,
  input  logic [W-1:0] opnd_i,
  input  logic         op_test_i,
  output logic [W-1:0] acc_o,
  output logic         flg_sign_o,
  output logic         flg_zero_o,
  output logic         flg_pv_o,
  output logic         flg_half_o,
  output logic         flg_sub_o,
  output logic         flg_carry_o,
  output logic         ult_o,
  output logic         slt_o,
  output logic         eq_o
);
  flags_t sub_fl;
  flags_t and_fl;
  flags_t sel_fl;

  cmpt_sub_path #(.W(W)) u_sub (
    .a_i   (acc_i),
    .b_i   (opnd_i),
    .fl_o  (sub_fl),
    .ult_o (ult_o),
    .slt_o (slt_o)
  );

  cmpt_and_path #(.W(W)) u_and (
    .a_i  (acc_i),
    .b_i  (opnd_i),
    .fl_o (and_fl)
  );

  always_comb begin
    sel_fl = op_test_i ? and_fl : sub_fl;
    acc_o  = acc_i;
    eq_o   = (acc_i == opnd_i);
  end

  assign flg_sign_o  = sel_fl.sign;
  assign flg_zero_o  = sel_fl.zero;
  assign flg_pv_o    = sel_fl.pv;
  assign flg_half_o  = sel_fl.half;
  assign flg_sub_o   = sel_fl.sub;
  assign flg_carry_o = sel_fl.carry;
endmodule

// File: rtl/cmpt_flag_unit_chk.sv
module cmpt_flag_unit_chk #(
  parameter int unsigned W = 8
) (
  input logic [W-1:0] acc_i,
  input logic [W-1:0] opnd_i,
  input logic         op_test_i,
  input logic [W-1:0] acc_o,
  input logic         flg_sign_o,
  input logic         flg_zero_o,
  input logic         flg_pv_o,
  input logic         flg_half_o,
  input logic         flg_sub_o,
  input logic         flg_carry_o,
  input logic         ult_o,
  input logic         slt_o,
  input logic         eq_o
);
  always_comb begin
    a_r1_acc_kept: assert (acc_o == acc_i);
    if (!op_test_i) begin
      a_r2_zero_is_eq:   assert (flg_zero_o == eq_o);
      a_r3_carry_is_ult: assert (flg_carry_o == ult_o);
      a_r5_slt_from_flags: assert (slt_o == (flg_sign_o ^ flg_pv_o));
      a_r6_sub_set:      assert (flg_sub_o);
    end else begin
      a_r9_test_consts:  assert (flg_half_o && !flg_sub_o && !flg_carry_o);
    end
    a_r2_eq_not_less: assert (!(eq_o && (ult_o || slt_o)));
  end
endmodule

bind cmpt_flag_unit cmpt_flag_unit_chk #(.W(W)) u_chk (
  .acc_i       (acc_i),
  .opnd_i      (opnd_i),
  .op_test_i   (op_test_i),
  .acc_o       (acc_o),
  .flg_sign_o  (flg_sign_o),
  .flg_zero_o  (flg_zero_o),
  .flg_pv_o    (flg_pv_o),
  .flg_half_o  (flg_half_o),
  .flg_sub_o   (flg_sub_o),
  .flg_carry_o (flg_carry_o),
  .ult_o       (ult_o),
  .slt_o       (slt_o),
  .eq_o        (eq_o)
);

// File: tb/cmpt_flag_unit_tb.sv
module cmpt_flag_unit_tb;
  typedef struct packed {
    logic [7:0] a;
    logic [7:0] n;
    logic       op;
    logic [5:0] fl;   // sign, zero, pv, half, sub, carry
    logic [2:0] ord;  // ult, slt, eq
  } vec_t;

  localparam int NVEC = 8;
  localparam vec_t VEC [NVEC] = '{
    '{8'h05, 8'h05, 1'b0, 6'b010010, 3'b001},  // R2 equal
    '{8'h03, 8'h05, 1'b0, 6'b100111, 3'b110},  // R3 R6 borrow
    '{8'h80, 8'h01, 1'b0, 6'b001110, 3'b010},  // R4 R5 overflow
    '{8'h7F, 8'hFF, 1'b0, 6'b101011, 3'b100},  // R4 R5 overflow, unsigned less
    '{8'hF0, 8'h0F, 1'b1, 6'b011100, 3'b010},  // R7 R8 zero product
    '{8'hFF, 8'h81, 1'b1, 6'b101100, 3'b000},  // R7 R8 even parity
    '{8'h07, 8'h03, 1'b1, 6'b001100, 3'b000},  // R8 even
    '{8'h07, 8'h07, 1'b1, 6'b000100, 3'b001}   // R8 odd, R2 eq in test
  };

  logic clk;
  logic rst_n;
  logic [7:0] acc_i, opnd_i, acc_o;
  logic op_test_i;
  logic s, z, pv, h, sb, c, ult, slt, eq;
  int n_chk, n_bad;
  bit done;

  cmpt_flag_unit u_dut (
    .acc_i(acc_i), .opnd_i(opnd_i), .op_test_i(op_test_i), .acc_o(acc_o),
    .flg_sign_o(s), .flg_zero_o(z), .flg_pv_o(pv), .flg_half_o(h),
    .flg_sub_o(sb), .flg_carry_o(c), .ult_o(ult), .slt_o(slt), .eq_o(eq)
  );

  initial clk = 1'b0;
  always #5 clk = ~clk;

  task automatic chk(input string req, input int got, input int exp);
    n_chk++;
    if (got != exp) begin
      n_bad++;
      $display("FAIL %s a=%02h n=%02h op=%0d got=%0h exp=%0h",
               req, acc_i, opnd_i, op_test_i, got, exp);
    end
  endtask

  task automatic drive(input logic [7:0] a, input logic [7:0] n, input logic op);
    acc_i = a; opnd_i = n; op_test_i = op;
    #3;
  endtask

  function automatic logic [5:0] model_fl(input logic [7:0] a, input logic [7:0] n, input logic op);
    logic [5:0] f;
    int d;
    int sd;
    logic [7:0] r;
    if (!op) begin
      d  = int'(a) - int'(n);
      sd = int'($signed(a)) - int'($signed(n));
      r  = d[7:0];
      f  = {r[7], a == n, (sd > 127) || (sd < -128), a[3:0] < n[3:0], 1'b1, a < n};
    end else begin
      r = a & n;
      f = {r[7], r == 8'h00, ($countones(r) % 2) == 0, 1'b1, 1'b0, 1'b0};
    end
    return f;
  endfunction

  function automatic logic [2:0] model_ord(input logic [7:0] a, input logic [7:0] n);
    return {a < n, $signed(a) < $signed(n), a == n};
  endfunction

  task automatic finish_run();
    if (!done) begin
      done = 1'b1;
      $display("*** SUMMARY: %0d compared / %0d mismatched ***", n_chk, n_bad);
      $finish;
    end
  endtask

  initial begin
    #1_000_000;
    n_chk++; n_bad++;
    $display("FAIL watchdog expired");
    finish_run();
  end

  initial begin
    n_chk = 0; n_bad = 0; done = 1'b0;
    rst_n = 1'b0;
    acc_i = 8'h00; opnd_i = 8'h00; op_test_i = 1'b0;
    repeat (2) @(posedge clk);
    #1;
    // R10 idle state: compare of 0 with 0
    chk("R10 idle flags", {s, z, pv, h, sb, c}, 6'b010010);
    chk("R1 idle acc", acc_o, 8'h00);
    rst_n = 1'b1;

    for (int i = 0; i < NVEC; i++) begin
      drive(VEC[i].a, VEC[i].n, VEC[i].op);
      chk("R4 R7 table flags", {s, z, pv, h, sb, c}, VEC[i].fl);
      chk("R3 R5 table ordering", {ult, slt, eq}, VEC[i].ord);
    end

    // R10: flags follow op select with no clock, same operands
    drive(8'h0F, 8'h0F, 1'b0);
    chk("R10 cmp sel", {h, sb}, 2'b01);
    drive(8'h0F, 8'h0F, 1'b1);
    chk("R10 test sel", {h, sb}, 2'b10);

    // exhaustive sweep, both modes
    for (int op = 0; op < 2; op++) begin
      for (int a = 0; a < 256; a++) begin
        for (int n = 0; n < 256; n++) begin
          drive(a[7:0], n[7:0], op[0]);
          chk("R1 acc", acc_o, a[7:0]);
          chk(op[0] ? "R8 R9 test flags" : "R6 compare flags",
              {s, z, pv, h, sb, c}, model_fl(a[7:0], n[7:0], op[0]));
          chk("R5 ordering", {ult, slt, eq}, model_ord(a[7:0], n[7:0]));
        end
      end
    end
    finish_run();
  end
endmodule